// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast clock by an integer count C and gives the divided clock a programmable high time. The high time is set in half-input-period units. That resolution comes from two registers: one updates on the rising input edge and one on the falling input edge. The output is the XOR of the two, so either edge can end the high phase. The low time is whatever remains of the 2C half-periods in each output period. With C = 10, for example, the duty cycle moves in 5% steps.

Settings are presented on the count, high-time and feedback-mode inputs and captured with a one-cycle load strobe. A captured legal setting waits in a pending slot and becomes active on the rising input edge that starts the next output period, so no output period is ever cut short. An illegal setting is refused: the active configuration is kept and an error flag rises. In feedback mode the high-time input is ignored and the high time is forced to C half-periods, which is exactly 50% even for odd C.

The period sequencer has three states: IDLE (after reset), HIGH_START (the current input cycle begins high) and LOW_START (the current input cycle begins low). It makes these transitions: IDLE to HIGH_START on the first rising edge; wrap into HIGH_START at each period start; HIGH_START to LOW_START when the high phase has ended; and LOW_START held until the wrap. The configuration holder has two states, STEADY and PENDING. It makes these transitions: STEADY to PENDING on a legal load; PENDING held on another legal load; and PENDING to STEADY at a period start, where the pending setting is applied.

Top module: `duty_clk_div`

## Requirements
- R1: Each output period lasts exactly 2C half-periods of the input clock (output frequency = input frequency / C), whatever the high time.
- R2: With an even high-time value H, the output stays high for exactly H half-periods from the start of each period, then stays low for the rest of it.
- R3: With an odd high-time value H, the output still stays high for exactly H half-periods; the high-to-low change then falls on a falling input edge.
- R4: A load with C >= 2 is legal only for H in 1..2C-2; with C = 1 only H = 1 is legal. A load outside this range sets cfg_err to 1 on the next rising edge and leaves the running output period and high time unchanged.
- R5: A load with C = 0 is illegal in every mode: cfg_err is set and the previous configuration is kept.
- R6: A load with fb_mode = 1 ignores high_halves and sets the high time to C half-periods (50%); it is legal for any C >= 1.
- R7: A legal setting loaded in the middle of a period takes effect only at the next rising edge that starts a period; the period in progress completes with its old length and high time.
- R8: While rst_n is low the output is low and the defaults (C = 4, H = 4) are active; the output goes high on the first rising input edge after rst_n is released.
- R9: A legal load clears cfg_err on the next rising edge.
- R10: With C = 1 and H = 1 the output follows the input clock: one half-period high and one half-period low.
- R11: cfg_err changes only on a rising edge at which cfg_load was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_count | input | CNT_W | Total division count C |
| high_halves | input | CNT_W+1 | High time in half input periods |
| fb_mode | input | 1 | Force 50% duty, ignoring high_halves |
| cfg_load | input | 1 | Capture the setting on this rising edge |
| clk_out | output | 1 | Divided clock |
| cfg_err | output | 1 | Last loaded setting was illegal |

## Verification
The checker checks several invariants on every rising edge. The period counter stays below the active count. The active configuration always lies inside the legal range. The active configuration changes only on a period-start edge. The error flag moves only after a load. The sequencer leaves IDLE straight into HIGH_START. What only the bench's scenarios can show is the shape of the output waveform: they measure the high time and the total period in half-periods, including the falling-edge transitions for odd high times. They also show that a mid-period load leaves the running period intact, and that refused settings keep the old waveform.

// File: rtl/dcdiv_pkg.sv
package dcdiv_pkg;

    // Period sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE       = 2'd0,
        SQ_HIGH_START = 2'd1,
        SQ_LOW_START  = 2'd2
    } seq_st_t;

    // Configuration holder states.
    typedef enum logic {
        CF_STEADY  = 1'b0,
        CF_PENDING = 1'b1
    } cfg_st_t;

endpackage

// File: rtl/dcdiv_cfg.sv
module dcdiv_cfg
    import dcdiv_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DEF_DIV  = 4,
    parameter int DEF_HIGH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] div_in,
    input  logic [CNT_W:0]   high_in,
    input  logic             fb_in,
    input  logic             wrap,
    output logic [CNT_W-1:0] cur_c,
    output logic [CNT_W:0]   cur_h,
    output logic [CNT_W:0]   nxt_h,
    output logic             cfg_err
);
    localparam int HW = CNT_W + 1;

    cfg_st_t          st_q, st_nx;
    logic [CNT_W-1:0] pend_c;
    logic [HW-1:0]    pend_h;
    logic [HW-1:0]    h_req;
    logic [HW-1:0]    h_max;
    logic             legal;

    // Legality of the setting on the inputs.
    always_comb begin
        h_req = fb_in ? {1'b0, div_in} : high_in;
        h_max = (div_in == CNT_W'(1)) ? HW'(1) : ({div_in, 1'b0} - HW'(2));
        legal = (div_in != '0) && (h_req != '0) && (h_req <= h_max);
    end

    // Holder transitions.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CF_STEADY: begin
                if (load && legal) st_nx = CF_PENDING;
            end
            CF_PENDING: begin
                if (load && legal) st_nx = CF_PENDING;
                else if (wrap)     st_nx = CF_STEADY;
            end
            default: st_nx = CF_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CF_STEADY;
        else        st_q <= st_nx;
    end

    // Pending slot, active configuration and error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_c   <= CNT_W'(DEF_DIV);
            cur_h   <= HW'(DEF_HIGH);
            pend_c  <= CNT_W'(DEF_DIV);
            pend_h  <= HW'(DEF_HIGH);
            cfg_err <= 1'b0;
        end else begin
            if (wrap && (st_q == CF_PENDING)) begin
                cur_c <= pend_c;
                cur_h <= pend_h;
            end
            if (load) begin
                if (legal) begin
                    pend_c  <= div_in;
                    pend_h  <= h_req;
                    cfg_err <= 1'b0;
                end else begin
                    cfg_err <= 1'b1;
                end
            end
        end
    end

    // High time the next period will use.
    always_comb begin
        nxt_h = (st_q == CF_PENDING) ? pend_h : cur_h;
    end

endmodule

// File: rtl/dcdiv_seq.sv
module dcdiv_seq
    import dcdiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cur_c,
    input  logic [CNT_W:0]   cur_h,
    input  logic [CNT_W:0]   nxt_h,
    output seq_st_t          state,
    output logic [CNT_W-1:0] cyc,
    output logic             wrap,
    output logic             rise_want,
    output logic             fall_want
);
    localparam int HW = CNT_W + 1;

    seq_st_t          st_nx;
    logic [CNT_W-1:0] cyc_nx;
    logic [HW-1:0]    h_eff;
    logic             first_high;

    // Period start and cycle index.
    always_comb begin
        wrap       = (state == SQ_IDLE) || (cyc >= (cur_c - CNT_W'(1)));
        cyc_nx     = wrap ? '0 : (cyc + CNT_W'(1));
        h_eff      = wrap ? nxt_h : cur_h;
        first_high = ({cyc_nx, 1'b0} < h_eff);
    end

    // Sequencer transitions.
    always_comb begin
        st_nx = state;
        unique case (state)
            SQ_IDLE:       st_nx = SQ_HIGH_START;
            SQ_HIGH_START: st_nx = first_high ? SQ_HIGH_START : SQ_LOW_START;
            SQ_LOW_START:  st_nx = wrap ? SQ_HIGH_START : SQ_LOW_START;
            default:       st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cyc   <= '0;
        end else begin
            state <= st_nx;
            cyc   <= cyc_nx;
        end
    end

    // Outputs: level wanted for each half of the input cycle.
    always_comb begin
        rise_want = (st_nx == SQ_HIGH_START);
        fall_want = (state != SQ_IDLE) && ({cyc, 1'b1} < cur_h);
    end

endmodule

// File: rtl/dcdiv_edge.sv
module dcdiv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_want,
    input  logic fall_want,
    output logic out
);
    logic p_q;
    logic n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= 1'b0;
        else        p_q <= rise_want ^ n_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= 1'b0;
        else        n_q <= fall_want ^ p_q;
    end

    assign out = p_q ^ n_q;

endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div
    import dcdiv_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DEF_DIV  = 4,
    parameter int DEF_HIGH = 4
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_count,
    input  logic [CNT_W:0]   high_halves,
    input  logic             fb_mode,
    input  logic             cfg_load,
    output logic             clk_out,
    output logic             cfg_err
);
    seq_st_t          state;
    logic [CNT_W-1:0] cyc;
    logic             wrap;
    logic [CNT_W-1:0] cur_c;
    logic [CNT_W:0]   cur_h;
    logic [CNT_W:0]   nxt_h;
    logic             rise_want;
    logic             fall_want;

    dcdiv_cfg #(.CNT_W(CNT_W), .DEF_DIV(DEF_DIV), .DEF_HIGH(DEF_HIGH)) u_cfg (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .div_in  (div_count),
        .high_in (high_halves),
        .fb_in   (fb_mode),
        .wrap    (wrap),
        .cur_c   (cur_c),
        .cur_h   (cur_h),
        .nxt_h   (nxt_h),
        .cfg_err (cfg_err)
    );

    dcdiv_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .cur_c     (cur_c),
        .cur_h     (cur_h),
        .nxt_h     (nxt_h),
        .state     (state),
        .cyc       (cyc),
        .wrap      (wrap),
        .rise_want (rise_want),
        .fall_want (fall_want)
    );

    dcdiv_edge u_edge (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .rise_want (rise_want),
        .fall_want (fall_want),
        .out       (clk_out)
    );

endmodule

// File: rtl/duty_clk_div_chk.sv
module duty_clk_div_chk
    import dcdiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             cfg_load,
    input logic             cfg_err,
    input logic             clk_out,
    input seq_st_t          state,
    input logic [CNT_W-1:0] cyc,
    input logic             wrap,
    input logic [CNT_W-1:0] cur_c,
    input logic [CNT_W:0]   cur_h
);
    logic [CNT_W:0] lim;
    always_comb lim = (cur_c == CNT_W'(1)) ? (CNT_W+1)'(1) : ({cur_c, 1'b0} - (CNT_W+1)'(2));

    // R8: output low while in reset
    always @(posedge clk_in) begin
        if (!rst_n) begin
            a_reset_low_r8: assert (clk_out == 1'b0);
        end
    end

    // R1: cycle index stays inside the active count
    p_cnt_bound_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state != SQ_IDLE) |-> (cyc < cur_c));

    // R4: active configuration is always legal
    p_cfg_legal_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (cur_c != '0) && (cur_h != '0) && (cur_h <= lim));

    // R7: active configuration changes only at a period start
    p_apply_boundary_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$past(wrap) |-> ($stable(cur_c) && $stable(cur_h)));

    // R11: error flag moves only after a load
    p_err_load_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$past(cfg_load) |-> $stable(cfg_err));

    // R8: first edge after reset starts a high phase
    p_first_high_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && ($past(state) == SQ_IDLE)) |-> (state == SQ_HIGH_START));

endmodule

bind duty_clk_div duty_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_err  (cfg_err),
    .clk_out  (clk_out),
    .state    (state),
    .cyc      (cyc),
    .wrap     (wrap),
    .cur_c    (cur_c),
    .cur_h    (cur_h)
);

// File: tb/duty_clk_div_test.sv
`timescale 1ns/1ps
module duty_clk_div_test;
    localparam int CNT_W = 8;

    typedef struct {
        int tot;
        int hi;
    } per_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] div_count = 8'd4;
    logic [CNT_W:0]   high_halves = 9'd4;
    logic             fb_mode = 1'b0;
    logic             cfg_load = 1'b0;
    logic             clk_out;
    logic             cfg_err;

    int     checks = 0;
    int     fails = 0;
    per_t   exp_q[$];
    string  exp_tag[$];
    bit     mon_en = 1'b0;
    int     rise_cnt = 0;
    logic   prev_s = 1'b0;
    bit     in_per = 1'b0;
    bit     per_valid = 1'b0;
    int     cur_tot = 0;
    int     cur_hi = 0;

    duty_clk_div #(.CNT_W(CNT_W)) uut (
        .clk_in      (clk),
        .rst_n       (rst_n),
        .div_count   (div_count),
        .high_halves (high_halves),
        .fb_mode     (fb_mode),
        .cfg_load    (cfg_load),
        .clk_out     (clk_out),
        .cfg_err     (cfg_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: one sample per half input period.
    initial begin
        forever begin
            @(clk);
            #1;
            if (!prev_s && clk_out) begin
                if (in_per && per_valid && exp_q.size() > 0) begin
                    per_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk(cur_tot == e.tot, {t, " period halves"}, cur_tot, e.tot);
                    chk(cur_hi == e.hi, {t, " high halves"}, cur_hi, e.hi);
                end
                in_per    = 1'b1;
                per_valid = mon_en;
                cur_tot   = 1;
                cur_hi    = 1;
                rise_cnt++;
            end else if (in_per) begin
                cur_tot++;
                if (clk_out) cur_hi++;
            end
            prev_s = clk_out;
        end
    end

    task automatic push_exp(input int n, input int tot, input int hi, input string tag);
        for (int i = 0; i < n; i++) begin
            per_t e;
            e.tot = tot;
            e.hi  = hi;
            exp_q.push_back(e);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic do_load(input int c, input int h, input bit fb);
        @(negedge clk);
        div_count   = CNT_W'(c);
        high_halves = (CNT_W+1)'(h);
        fb_mode     = fb;
        cfg_load    = 1'b1;
        @(negedge clk);
        cfg_load    = 1'b0;
    endtask

    task automatic run_exp(input int n, input int tot, input int hi, input string tag);
        int r0;
        mon_en = 1'b0;
        r0 = rise_cnt;
        wait (rise_cnt >= r0 + 2);
        mon_en = 1'b1;
        push_exp(n, tot, hi, tag);
        wait (exp_q.size() == 0);
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(clk_out == 1'b0, "R8 low in reset", clk_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(clk_out == 1'b1, "R8 high on first edge", clk_out, 1);

        // Defaults C=4 H=4, then a mid-period load of C=3 H=3.
        begin
            int r0;
            mon_en = 1'b1;
            push_exp(1, 8, 4, "R7 old period kept");
            r0 = rise_cnt;
            wait (rise_cnt > r0);
            repeat (2) @(posedge clk);
            do_load(3, 3, 1'b0);
            push_exp(2, 6, 3, "R7 R3 new odd setting");
            wait (exp_q.size() == 0);
            mon_en = 1'b0;
        end

        do_load(5, 4, 1'b0);
        run_exp(3, 10, 4, "R1 R2 C=5 H=4");

        do_load(10, 1, 1'b0);
        run_exp(2, 20, 1, "R4 lowest duty");
        do_load(10, 18, 1'b0);
        run_exp(2, 20, 18, "R4 highest duty");
        chk(cfg_err == 1'b0, "R4 legal no error", cfg_err, 0);

        do_load(10, 19, 1'b0);
        chk(cfg_err == 1'b1, "R4 over range error", cfg_err, 1);
        run_exp(2, 20, 18, "R4 previous kept");
        chk(cfg_err == 1'b1, "R11 error held without load", cfg_err, 1);

        do_load(0, 1, 1'b1);
        chk(cfg_err == 1'b1, "R5 zero count error", cfg_err, 1);
        run_exp(2, 20, 18, "R5 previous kept");

        do_load(7, 5, 1'b0);
        chk(cfg_err == 1'b0, "R9 error cleared", cfg_err, 0);
        run_exp(2, 14, 5, "R3 C=7 H=5");

        do_load(7, 2, 1'b1);
        run_exp(2, 14, 7, "R6 feedback odd C");
        do_load(6, 1, 1'b1);
        run_exp(2, 12, 6, "R6 feedback even C");

        do_load(1, 1, 1'b0);
        run_exp(4, 2, 1, "R10 pass-through");
        do_load(1, 2, 1'b0);
        chk(cfg_err == 1'b1, "R4 C=1 H=2 error", cfg_err, 1);
        run_exp(2, 2, 1, "R4 C=1 kept");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule